// File: doc/BRIEF.md
# PCI Configuration Cycle Translator

This block sits between a host register port and a PCI master engine and turns configuration mechanism #1 accesses into configuration transactions. The host first writes a configuration address word (enable, bus, device, function, register) into an address register. A later read or write of the data register is then decoded into one of three outcomes. It may be an access to the bridge's own configuration space over a separate local port. It may be a Type0 cycle on the local PCI bus, or a Type1 cycle aimed at a bus behind another bridge.

For Type0 cycles the block builds a one-hot device select on the upper address lines, so that each slot's select input can be resistively coupled to one AD line. Every configuration cycle is address-stepped. The address and command are presented for a configurable number of clocks before the master engine is asked to start the frame, which gives the coupled select lines time to settle. The host port stalls until the chosen target has completed.

The sequencer has five states. S_IDLE waits for a host access. S_STEP holds the address phase during stepping. S_ISSUE requests the PCI cycle. S_LOCAL requests the internal access. S_REPLY returns the result for one cycle. The transitions are as follows. S_IDLE goes to S_STEP on an enabled Type0/Type1 data access, or to S_ISSUE when stepping is zero. It goes to S_LOCAL on an enabled local data access, and to S_REPLY on anything else. S_STEP goes to S_ISSUE when its counter expires. S_ISSUE goes to S_REPLY on master completion, and S_LOCAL goes to S_REPLY on local completion. S_REPLY always goes back to S_IDLE.

Top module: `pcx_cfg_xlate`

## Requirements
- R1: After reset, host_ready, mst_addr_valid, mst_req and int_req are low, and the address register reads back as zero.
- R2: The address register sits at offset CA_OFS (default 0xCF8, second instance 0xCF0). Only bit 31 and bits 23:2 are writable, and the other bits read as zero. An access to it completes with host_ready high in the cycle after host_valid is first sampled.
- R3: The address word has the enable at bit 31, the bus at bits 23:16, the device at bits 15:11, the function at bits 10:8 and the register at bits 7:2. A data register access (offset CD_OFS, default 0xCFC) while the enable is clear issues neither a PCI nor a local access. Its read returns 0xFFFFFFFF.
- R4: An enabled data access with bus 0 and device 0 raises int_req with the function, the register index, the direction and the write data, and never raises mst_req. A read returns int_rdata.
- R5: An enabled data access with bus 0 and device n in 1..21 presents a Type0 address. AD[10+n] is the only set bit within AD[31:11], AD[10:8] is the function, AD[7:2] is the register and AD[1:0] is 00.
- R6: For a Type0 access with device 22..31, AD[31:11] is all zero and the cycle is still issued.
- R7: An enabled data access with a nonzero bus presents the Type1 address {8'h00, bus, device, function, register, 2'b01}.
- R8: The command is 4'b1010 for a configuration read and 4'b1011 for a configuration write. mst_wdata carries the host write data.
- R9: mst_addr_valid holds a stable address and command for exactly STEP_CLKS cycles (default 1) before mst_req rises. mst_req then stays high until mst_done.
- R10: host_ready pulses for one cycle, in the cycle after mst_done or int_done is sampled high. A read returns the data captured with that completion.
- R11: Accesses to any other offset complete in the next cycle, return zero, and leave the address register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_valid | input | 1 | Host access request, held until host_ready |
| host_write | input | 1 | 1 = write, 0 = read |
| host_addr | input | HA_W | Host register offset |
| host_wdata | input | 32 | Host write data |
| host_ready | output | 1 | One-cycle completion pulse |
| host_rdata | output | 32 | Read data, valid with host_ready |
| mst_addr_valid | output | 1 | Address phase presented (stepping and issue) |
| mst_req | output | 1 | Start the configuration frame |
| mst_ad | output | 32 | Configuration address for the AD lines |
| mst_cmd | output | 4 | Bus command |
| mst_wdata | output | 32 | Write data for the data phase |
| mst_done | input | 1 | Master engine completion |
| mst_rdata | input | 32 | Read data from the bus |
| int_req | output | 1 | Request to internal configuration space |
| int_write | output | 1 | Direction of the internal access |
| int_fn | output | 3 | Function number |
| int_reg | output | 6 | Register index |
| int_wdata | output | 32 | Internal write data |
| int_done | input | 1 | Internal access completion |
| int_rdata | input | 32 | Internal read data |

## Verification
An address-register or unmapped access completes one cycle after it is accepted. A PCI data access shows mst_addr_valid from the next cycle and raises mst_req after STEP_CLKS further cycles. Every PCI or local access answers with host_ready exactly one cycle after its completion input is seen. The bench counts the address-valid-without-request cycles and stamps the cycle in which its responder raises a completion, then checks that the ready pulse arrives one cycle later. Address, command and local-port fields are captured when first presented and compared with values that bench functions compute from a shadow of the address register.

// File: rtl/pcx_pkg.sv
package pcx_pkg;

    localparam int IDSEL_W = 21;

    localparam logic [3:0]  CMD_CFG_RD = 4'b1010;
    localparam logic [3:0]  CMD_CFG_WR = 4'b1011;
    localparam logic [31:0] CFG_WMASK  = 32'h80FF_FFFC;

    typedef enum logic [1:0] {
        TGT_NONE,
        TGT_LOCAL,
        TGT_TYPE0,
        TGT_TYPE1
    } tgt_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_STEP,
        S_ISSUE,
        S_LOCAL,
        S_REPLY
    } st_e;

endpackage

// File: rtl/pcx_cfgaddr.sv
module pcx_cfgaddr
    import pcx_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        we,
    input  logic [31:0] wdata,
    output logic [31:0] q
);

    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= '0;
        else if (we)
            q <= wdata & CFG_WMASK;
    end

endmodule

// File: rtl/pcx_decode.sv
module pcx_decode
    import pcx_pkg::*;
(
    input  logic        en,
    input  logic [21:0] fields,   // bus[21:14] dev[13:9] fn[8:6] reg[5:0]
    output tgt_e        tgt,
    output logic [31:0] ad
);

    logic [7:0]         bus;
    logic [4:0]         dev;
    logic [2:0]         fn;
    logic [5:0]         rg;
    logic [IDSEL_W-1:0] idsel;

    assign bus = fields[21:14];
    assign dev = fields[13:9];
    assign fn  = fields[8:6];
    assign rg  = fields[5:0];

    // one select line per decodable device number, device g+1 -> line g
    genvar g;
    generate
        for (g = 0; g < IDSEL_W; g++) begin : g_sel
            assign idsel[g] = (dev == 5'(g + 1));
        end
    endgenerate

    always_comb begin
        if (!en)
            tgt = TGT_NONE;
        else if (bus != 8'h00)
            tgt = TGT_TYPE1;
        else if (dev != 5'd0)
            tgt = TGT_TYPE0;
        else
            tgt = TGT_LOCAL;
    end

    always_comb begin
        if (tgt == TGT_TYPE1)
            ad = {8'h00, fields, 2'b01};
        else
            ad = {idsel, fn, rg, 2'b00};
    end

endmodule

// File: rtl/pcx_cfg_xlate.sv
module pcx_cfg_xlate
    import pcx_pkg::*;
#(
    parameter int              HA_W      = 12,
    parameter logic [HA_W-1:0] CA_OFS    = 12'hCF8,
    parameter logic [HA_W-1:0] CD_OFS    = 12'hCFC,
    parameter int              STEP_CLKS = 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            host_valid,
    input  logic            host_write,
    input  logic [HA_W-1:0] host_addr,
    input  logic [31:0]     host_wdata,
    output logic            host_ready,
    output logic [31:0]     host_rdata,
    output logic            mst_addr_valid,
    output logic            mst_req,
    output logic [31:0]     mst_ad,
    output logic [3:0]      mst_cmd,
    output logic [31:0]     mst_wdata,
    input  logic            mst_done,
    input  logic [31:0]     mst_rdata,
    output logic            int_req,
    output logic            int_write,
    output logic [2:0]      int_fn,
    output logic [5:0]      int_reg,
    output logic [31:0]     int_wdata,
    input  logic            int_done,
    input  logic [31:0]     int_rdata
);

    localparam int SC_W = $clog2(STEP_CLKS + 2);

    st_e               st, st_nx;
    logic [SC_W-1:0]   step_q;
    logic [31:0]       cfg_q;
    tgt_e              tgt;
    logic [31:0]       dec_ad;
    logic              hit_ca, hit_cd, cfg_we;
    logic              wr_q;
    logic [31:0]       wd_q, ad_q, rdata_q;
    logic [2:0]        fn_q;
    logic [5:0]        rg_q;

    assign hit_ca = (host_addr == CA_OFS);
    assign hit_cd = (host_addr == CD_OFS);
    assign cfg_we = (st == S_IDLE) && host_valid && host_write && hit_ca;

    pcx_cfgaddr u_cfgaddr (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .wdata (host_wdata),
        .q     (cfg_q)
    );

    pcx_decode u_decode (
        .en     (cfg_q[31]),
        .fields (cfg_q[23:2]),
        .tgt    (tgt),
        .ad     (dec_ad)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n)
            st <= S_IDLE;
        else
            st <= st_nx;
    end

    // next state
    always_comb begin
        st_nx = st;
        unique case (st)
            S_IDLE: begin
                if (host_valid) begin
                    if (hit_cd && tgt == TGT_LOCAL)
                        st_nx = S_LOCAL;
                    else if (hit_cd && (tgt == TGT_TYPE0 || tgt == TGT_TYPE1))
                        st_nx = (STEP_CLKS == 0) ? S_ISSUE : S_STEP;
                    else
                        st_nx = S_REPLY;
                end
            end
            S_STEP:  if (step_q == SC_W'(1)) st_nx = S_ISSUE;
            S_ISSUE: if (mst_done) st_nx = S_REPLY;
            S_LOCAL: if (int_done) st_nx = S_REPLY;
            S_REPLY: st_nx = S_IDLE;
            default: st_nx = S_IDLE;
        endcase
    end

    // outputs decoded from state
    always_comb begin
        host_ready     = 1'b0;
        mst_addr_valid = 1'b0;
        mst_req        = 1'b0;
        int_req        = 1'b0;
        unique case (st)
            S_IDLE:  ;
            S_STEP:  mst_addr_valid = 1'b1;
            S_ISSUE: begin
                mst_addr_valid = 1'b1;
                mst_req        = 1'b1;
            end
            S_LOCAL: int_req    = 1'b1;
            S_REPLY: host_ready = 1'b1;
            default: ;
        endcase
    end

    // transaction capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_q    <= 1'b0;
            wd_q    <= '0;
            ad_q    <= '0;
            fn_q    <= '0;
            rg_q    <= '0;
            rdata_q <= '0;
            step_q  <= '0;
        end else begin
            unique case (st)
                S_IDLE: begin
                    if (host_valid) begin
                        wr_q   <= host_write;
                        wd_q   <= host_wdata;
                        ad_q   <= dec_ad;
                        fn_q   <= cfg_q[10:8];
                        rg_q   <= cfg_q[7:2];
                        step_q <= SC_W'(STEP_CLKS);
                        if (hit_ca)
                            rdata_q <= cfg_q;
                        else if (hit_cd && tgt == TGT_NONE)
                            rdata_q <= '1;
                        else
                            rdata_q <= '0;
                    end
                end
                S_STEP:  step_q <= step_q - SC_W'(1);
                S_ISSUE: if (mst_done) rdata_q <= mst_rdata;
                S_LOCAL: if (int_done) rdata_q <= int_rdata;
                default: ;
            endcase
        end
    end

    assign host_rdata = rdata_q;
    assign mst_ad     = ad_q;
    assign mst_cmd    = wr_q ? CMD_CFG_WR : CMD_CFG_RD;
    assign mst_wdata  = wd_q;
    assign int_write  = wr_q;
    assign int_fn     = fn_q;
    assign int_reg    = rg_q;
    assign int_wdata  = wd_q;

endmodule

// File: rtl/pcx_checker.sv
module pcx_checker #(
    parameter int STEP_CLKS = 1
) (
    input logic        clk,
    input logic        rst_n,
    input logic        host_ready,
    input logic        mst_addr_valid,
    input logic        mst_req,
    input logic        mst_done,
    input logic [31:0] mst_ad,
    input logic [3:0]  mst_cmd,
    input logic        int_req
);

    logic [15:0] run_q;

    always_ff @(posedge clk) begin
        if (!rst_n)
            run_q <= '0;
        else if (!mst_addr_valid)
            run_q <= '0;
        else if (!mst_req && run_q != 16'hFFFF)
            run_q <= run_q + 16'd1;
    end

    AST_REPLY_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        host_ready |=> !host_ready);                                           // R10

    AST_ONE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        !(mst_req && int_req));                                                // R4

    AST_STEP_SETTLE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mst_req) |-> (32'(run_q) >= 32'(STEP_CLKS)));                    // R9

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mst_req && !mst_done) |=> mst_req);                                   // R9

    AST_AD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (mst_addr_valid && $past(mst_addr_valid)) |-> ($stable(mst_ad) && $stable(mst_cmd))); // R9

    AST_IDSEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        (mst_addr_valid && mst_ad[1:0] == 2'b00) |-> $onehot0(mst_ad[31:11])); // R5

    AST_CMD_CFG: assert property (@(posedge clk) disable iff (!rst_n)
        mst_addr_valid |-> (mst_cmd[3:1] == 3'b101));                          // R8

endmodule

bind pcx_cfg_xlate pcx_checker #(.STEP_CLKS(STEP_CLKS)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .host_ready     (host_ready),
    .mst_addr_valid (mst_addr_valid),
    .mst_req        (mst_req),
    .mst_done       (mst_done),
    .mst_ad         (mst_ad),
    .mst_cmd        (mst_cmd),
    .int_req        (int_req)
);

// File: tb/sim_pcx_cfg_xlate.sv
module sim_pcx_cfg_xlate;

    localparam int          STEP = 1;
    localparam logic [11:0] CA   = 12'hCF8;
    localparam logic [11:0] CD   = 12'hCFC;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        host_valid, host_write;
    logic [11:0] host_addr;
    logic [31:0] host_wdata, host_rdata;
    logic        host_ready;
    logic        mst_addr_valid, mst_req, mst_done;
    logic [31:0] mst_ad, mst_wdata, mst_rdata;
    logic [3:0]  mst_cmd;
    logic        int_req, int_write, int_done;
    logic [2:0]  int_fn;
    logic [5:0]  int_reg;
    logic [31:0] int_wdata, int_rdata;

    int checks = 0, errors = 0, cyc = 0, done_cyc = 0;
    logic [31:0] cfg_m = '0;

    // observations of the last host access
    int          n_cyc, step_n, ready_cyc;
    bit          seen_av, seen_req, seen_int;
    logic [31:0] o_ad, o_wd, o_iwd;
    logic [3:0]  o_cmd;
    logic [2:0]  o_fn;
    logic [5:0]  o_rg;
    logic        o_iwr;

    pcx_cfg_xlate #(.HA_W(12), .CA_OFS(CA), .CD_OFS(CD), .STEP_CLKS(STEP)) u0 (.*);

    always #5 clk = ~clk;
    always @(posedge clk) cyc++;

    function automatic logic [31:0] pci_resp(input logic [31:0] a);
        return a ^ 32'h5A5A_0F0F;
    endfunction

    function automatic logic [31:0] loc_resp(input logic [2:0] f, input logic [5:0] r);
        return 32'hC0DE_0000 | {23'd0, f, r};
    endfunction

    function automatic logic [20:0] exp_idsel(input logic [4:0] d);
        if (d >= 5'd1 && d <= 5'd21) return 21'd1 << (d - 5'd1);
        return '0;
    endfunction

    function automatic logic [31:0] exp_ad(input logic [31:0] c);
        if (c[23:16] != 8'h00) return {8'h00, c[23:2], 2'b01};
        return {exp_idsel(c[15:11]), c[10:8], c[7:2], 2'b00};
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // completion models for the master engine and the local space
    initial begin
        int lm, li;
        lm = 0; li = 0;
        mst_done = 0; int_done = 0; mst_rdata = '0; int_rdata = '0;
        forever begin
            @(negedge clk);
            if (mst_done) mst_done = 0;
            else if (mst_req) begin
                if (lm == 0) begin
                    mst_done = 1; mst_rdata = pci_resp(mst_ad); done_cyc = cyc; lm = $urandom % 4;
                end else lm--;
            end
            if (int_done) int_done = 0;
            else if (int_req) begin
                if (li == 0) begin
                    int_done = 1; int_rdata = loc_resp(int_fn, int_reg); done_cyc = cyc; li = $urandom % 4;
                end else li--;
            end
        end
    end

    task automatic host_acc(input logic wr, input logic [11:0] a, input logic [31:0] d, output logic [31:0] rd);
        @(negedge clk);
        host_valid = 1; host_write = wr; host_addr = a; host_wdata = d;
        n_cyc = 0; step_n = 0; seen_av = 0; seen_req = 0; seen_int = 0;
        forever begin
            @(negedge clk);
            n_cyc++;
            if (mst_addr_valid && !seen_av) begin
                seen_av = 1; o_ad = mst_ad; o_cmd = mst_cmd; o_wd = mst_wdata;
            end
            if (mst_addr_valid && !mst_req) step_n++;
            if (mst_req) seen_req = 1;
            if (int_req && !seen_int) begin
                seen_int = 1; o_fn = int_fn; o_rg = int_reg; o_iwr = int_write; o_iwd = int_wdata;
            end
            if (host_ready || n_cyc > 100) break;
        end
        ready_cyc = cyc;
        chk(host_ready, "R10 ready seen", 32'(host_ready), 32'd1);
        rd = host_rdata;
        host_valid = 0;
    endtask

    task automatic cfg_write(input logic [31:0] w);
        logic [31:0] rd;
        host_acc(1'b1, CA, w, rd);
        cfg_m = w & 32'h80FF_FFFC;
        chk(n_cyc == 1, "R2 write latency", 32'(n_cyc), 32'd1);
    endtask

    task automatic cfg_read();
        logic [31:0] rd;
        host_acc(1'b0, CA, '0, rd);
        chk(rd == cfg_m, "R2 readback", rd, cfg_m);
        chk(n_cyc == 1, "R2 read latency", 32'(n_cyc), 32'd1);
    endtask

    task automatic data_acc(input logic wr, input logic [31:0] d);
        logic [31:0] rd, ea;
        string tg;
        host_acc(wr, CD, d, rd);
        if (!cfg_m[31]) begin
            chk(!seen_av && !seen_int, "R3 no cycle when disabled", {seen_av, seen_int}, 32'd0);
            if (!wr) chk(rd == 32'hFFFF_FFFF, "R3 disabled read", rd, 32'hFFFF_FFFF);
        end else if (cfg_m[23:16] != 0 || cfg_m[15:11] != 0) begin
            ea = exp_ad(cfg_m);
            tg = (cfg_m[23:16] != 0) ? "R7 type1 address" :
                 (cfg_m[15:11] > 21) ? "R6 no-select address" : "R5 type0 address";
            chk(seen_av && o_ad == ea, tg, o_ad, ea);
            chk(o_cmd == (wr ? 4'b1011 : 4'b1010), "R8 command", 32'(o_cmd), wr ? 32'hB : 32'hA);
            if (wr) chk(o_wd == d, "R8 write data", o_wd, d);
            chk(step_n == STEP && seen_req, "R9 stepping clocks", 32'(step_n), 32'(STEP));
            chk(!seen_int, "R4 no local access on bus cycle", 32'(seen_int), 32'd0);
            chk(ready_cyc == done_cyc + 1, "R10 ready timing", 32'(ready_cyc), 32'(done_cyc + 1));
            if (!wr) chk(rd == pci_resp(ea), "R10 bus read data", rd, pci_resp(ea));
        end else begin
            chk(seen_int && !seen_av, "R4 local routing", {seen_int, seen_av}, 32'd2);
            chk(o_fn == cfg_m[10:8] && o_rg == cfg_m[7:2] && o_iwr == wr,
                "R4 local fields", {o_iwr, o_fn, o_rg}, {wr, cfg_m[10:2]});
            if (wr) chk(o_iwd == d, "R4 local write data", o_iwd, d);
            chk(ready_cyc == done_cyc + 1, "R10 ready timing", 32'(ready_cyc), 32'(done_cyc + 1));
            if (!wr) chk(rd == loc_resp(cfg_m[10:8], cfg_m[7:2]), "R4 local read data",
                         rd, loc_resp(cfg_m[10:8], cfg_m[7:2]));
        end
    endtask

    function automatic logic [31:0] rnd_cfg();
        logic [31:0] w;
        w = $urandom;
        if ($urandom % 2 == 0) w[23:16] = 8'h00;
        if ($urandom % 8 == 0) w[15:11] = 5'd0;
        w[31] = ($urandom % 10 != 0);
        return w;
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL R10 watchdog actual=hung expected=finished");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] rd;
        void'($urandom(32'd1234));
        rst_n = 0; host_valid = 0; host_write = 0; host_addr = '0; host_wdata = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        // R1 reset state
        chk(!host_ready && !mst_addr_valid && !mst_req && !int_req, "R1 idle outputs",
            {host_ready, mst_addr_valid, mst_req, int_req}, 32'd0);
        host_acc(1'b0, CA, '0, rd);
        chk(rd == 32'd0, "R1 address register reset", rd, 32'd0);

        // R2 writable bits
        cfg_write(32'hFFFF_FFFF);
        cfg_read();

        // R11 other offsets
        host_acc(1'b1, 12'h000, 32'h8001_0800, rd);
        chk(n_cyc == 1 && !seen_av && !seen_int, "R11 other offset write", 32'(n_cyc), 32'd1);
        host_acc(1'b0, 12'hCF4, '0, rd);
        chk(rd == 32'd0, "R11 other offset read", rd, 32'd0);
        cfg_read();

        // directed device numbers
        cfg_write(32'h8000_0800 | (32'd5 << 8) | (32'd9 << 2)); data_acc(1'b0, '0); // dev 1
        cfg_write(32'h8000_A800 | (32'd2 << 2));  data_acc(1'b1, 32'hDEAD_BEEF);      // dev 21
        cfg_write(32'h8000_B000);                 data_acc(1'b0, '0);                 // dev 22
        cfg_write(32'h8000_F8FC);                 data_acc(1'b1, 32'h1111_2222);      // dev 31
        cfg_write(32'h8005_1A14);                 data_acc(1'b0, '0);                 // bus 5
        cfg_write(32'h80FF_FFFC);                 data_acc(1'b1, 32'h3333_4444);      // bus 255
        cfg_write(32'h8000_0310);                 data_acc(1'b0, '0);                 // local
        data_acc(1'b1, 32'h5555_6666);
        cfg_write(32'h0000_0800);                 data_acc(1'b0, '0);                 // disabled
        data_acc(1'b1, 32'h7777_8888);
        cfg_read();

        for (int i = 0; i < 400; i++) begin
            int op;
            op = $urandom % 10;
            if (op < 2) cfg_write(rnd_cfg());
            else if (op == 2) cfg_read();
            else data_acc(1'($urandom % 2), $urandom);
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule